// File: doc/BRIEF.md
# Keyed Register Write Guard

This block sits between a simple register bus and the configuration registers of a peripheral. It decides, for every bus write, whether a protected configuration register may take the written value. Its answer is a one-hot allow vector with one bit for each protected register, and that vector is valid in the same cycle as the write strobe. While protection is on, every write to a protected address is refused. The block then raises an error flag and latches the refused address into a status word that software can read.

Protection is switched on or off only through a dedicated lock-control address. A write to that address changes the lock only when the upper 24 data bits carry a fixed key. The default key is the ASCII string "DAC", which is 0x444143. A lock-control write with any other key is dropped silently. Reading the status word returns the flag and the captured address, and the read clears both of them one cycle later. The protected registers themselves live outside the block; they simply qualify their own write enables with the allow vector.

Top module: `wp_guard`

## Requirements
- R1: After a synchronous reset, `prot_on` is 0, `stat_rdata` is all zeros, and `wr_allow` is all zeros while no write is driven.
- R2: A write to `LOCK_ADDR` whose data bits [31:8] equal `KEY` loads data bit 0 into the lock. `prot_on` shows the new value from the next cycle. The key is needed both to set and to clear the lock.
- R3: A write to `LOCK_ADDR` with any other value in bits [31:8] leaves `prot_on` unchanged and does not alter `stat_rdata`.
- R4: While `prot_on` is 0, a write to protected address `PROT_ADDRS[i]` raises `wr_allow[i]` in the same cycle, and only that bit. Defaults: bit 0 is 0x04 and bit 1 is 0x08.
- R5: While `prot_on` is 1, `wr_allow` stays all zeros whatever is written.
- R6: A write to a protected address while `prot_on` is 1 sets `stat_rdata[0]` and loads the write address into `stat_rdata[8+:ADDR_W]` from the next cycle. All other status bits read 0.
- R7: While `stat_rd` is high, `stat_rdata` shows the current status. In the following cycle the flag and the address read as zero.
- R8: After several refused writes with no read between them, the status holds the address of the most recent one.
- R9: A refused write in the same cycle as a status read wins: the next cycle shows the flag set and the new address.
- R10: A write to an address that is neither protected nor `LOCK_ADDR` raises no allow bit and changes neither the lock nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register-bus write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 32 | Write data |
| stat_rd | input | 1 | Status read strobe (clear-on-read) |
| wr_allow | output | PROT_CNT | Per-register write permission, same cycle as the write |
| prot_on | output | 1 | Current lock state |
| stat_rdata | output | 32 | Status word: bit 0 error flag, bits [8+:ADDR_W] refused address |

## Verification
The checker enforces several rules on every cycle. The allow vector stays silent while locked and never has more than one bit set. A keyed lock write moves the lock to the written bit, and an unkeyed one leaves it alone. A refused write always leaves the flag set with its own address. A read with no coinciding violation always clears the status, and with neither a read nor a violation the status holds. The bench scenarios cover what depends on history. These are the choice of the latest address among several violations, violation-over-clear precedence, relocking after a wrong-key unlock attempt, and writes being allowed again once the lock is cleared.

// File: rtl/wp_pkg.sv
// Package: shared constants and the write classification type for the
// keyed write guard. Assumes a 32-bit register bus.
package wp_pkg;
    localparam int DATA_W        = 32;
    localparam int KEY_W         = 24;
    localparam int LOCK_EN_BIT   = 0;
    localparam int LOCK_KEY_LSB  = 8;
    localparam int STAT_ERR_BIT  = 0;
    localparam int STAT_ADDR_LSB = 8;

    // Kind of access seen on the bus in the current cycle.
    typedef enum logic [2:0] {
        WR_NONE    = 3'd0,
        WR_LOCK_OK = 3'd1,
        WR_LOCK_BAD = 3'd2,
        WR_PROT    = 3'd3,
        WR_OTHER   = 3'd4
    } wr_class_e;
endpackage

// File: rtl/wp_wr_classify.sv
// Module: wp_wr_classify
// Sorts each bus write into one class and produces a one-hot select of
// the protected register addressed. Purely combinational.
// Assumes the lock-control address is not also listed as protected; if
// it is, the lock-control decode takes priority.
module wp_wr_classify #(
    parameter int ADDR_W   = 8,
    parameter int PROT_CNT = 2,
    parameter logic [PROT_CNT*ADDR_W-1:0] PROT_ADDRS = {8'h08, 8'h04},
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hE4,
    parameter logic [wp_pkg::KEY_W-1:0] KEY = 24'h444143
) (
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [wp_pkg::DATA_W-1:0] bus_wdata,
    output wp_pkg::wr_class_e         wr_class,
    output logic [PROT_CNT-1:0]       prot_sel
);
    import wp_pkg::*;

    logic [PROT_CNT-1:0] addr_match;
    logic                lock_hit;
    logic                key_ok;

    // One comparator per protected address.
    for (genvar gi = 0; gi < PROT_CNT; gi++) begin : g_match
        assign addr_match[gi] = (bus_addr == PROT_ADDRS[gi*ADDR_W +: ADDR_W]);
    end

    assign lock_hit = (bus_addr == LOCK_ADDR);
    assign key_ok   = (bus_wdata[LOCK_KEY_LSB +: KEY_W] == KEY);

    // Pick one class for the current access, lock decode first.
    always_comb begin
        wr_class = WR_NONE;
        if (bus_wr) begin
            if (lock_hit)
                wr_class = key_ok ? WR_LOCK_OK : WR_LOCK_BAD;
            else if (|addr_match)
                wr_class = WR_PROT;
            else
                wr_class = WR_OTHER;
        end
    end

    // Select lines only count for a real protected write.
    assign prot_sel = (wr_class == WR_PROT) ? addr_match : '0;
endmodule

// File: rtl/wp_lock_reg.sv
// Module: wp_lock_reg
// Holds the lock bit. Only a correctly keyed lock-control write changes it.
// Assumes synchronous active-low reset; resets to unlocked.
module wp_lock_reg (
    input  logic              clk,
    input  logic              rst_n,
    input  wp_pkg::wr_class_e wr_class,
    input  logic              new_lock,
    output logic              prot_on
);
    import wp_pkg::*;

    // Load the lock bit on a keyed write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_on <= 1'b0;
        else if (wr_class == WR_LOCK_OK)
            prot_on <= new_lock;
    end
endmodule

// File: rtl/wp_viol_log.sv
// Module: wp_viol_log
// Records refused writes: an error flag plus the latest refused address.
// A status read clears both; a violation in the same cycle overrides the
// clear. Assumes synchronous active-low reset.
module wp_viol_log #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol,
    input  logic [ADDR_W-1:0] viol_addr,
    input  logic              stat_rd,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    // Capture on violation, clear on read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (viol) begin
            err_flag <= 1'b1;
            err_addr <= viol_addr;
        end else if (stat_rd) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end
    end
endmodule

// File: rtl/wp_guard.sv
// Module: wp_guard (top)
// Keyed write guard for a peripheral's configuration registers. Produces a
// same-cycle allow vector for protected writes, a key-gated lock bit and a
// clear-on-read status word. Assumes ADDR_W <= 24 so the address fits the
// status word, and one bus write per cycle at most.
module wp_guard #(
    parameter int ADDR_W   = 8,
    parameter int PROT_CNT = 2,
    parameter logic [PROT_CNT*ADDR_W-1:0] PROT_ADDRS = {8'h08, 8'h04},
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hE4,
    parameter logic [wp_pkg::KEY_W-1:0] KEY = 24'h444143
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                stat_rd,
    output logic [PROT_CNT-1:0] wr_allow,
    output logic                prot_on,
    output logic [31:0]         stat_rdata
);
    import wp_pkg::*;

    wr_class_e           wr_class;
    logic [PROT_CNT-1:0] prot_sel;
    logic                prot_hit;
    logic                viol;
    logic                err_flag;
    logic [ADDR_W-1:0]   err_addr;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata[LOCK_KEY_LSB-1:LOCK_EN_BIT+1];

    wp_wr_classify #(
        .ADDR_W    (ADDR_W),
        .PROT_CNT  (PROT_CNT),
        .PROT_ADDRS(PROT_ADDRS),
        .LOCK_ADDR (LOCK_ADDR),
        .KEY       (KEY)
    ) u_classify (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .wr_class (wr_class),
        .prot_sel (prot_sel)
    );

    wp_lock_reg u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_class(wr_class),
        .new_lock(bus_wdata[LOCK_EN_BIT]),
        .prot_on (prot_on)
    );

    assign prot_hit = |prot_sel;
    assign viol     = prot_hit & prot_on;

    wp_viol_log #(.ADDR_W(ADDR_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .viol     (viol),
        .viol_addr(bus_addr),
        .stat_rd  (stat_rd),
        .err_flag (err_flag),
        .err_addr (err_addr)
    );

    // Pass the select through only while unlocked.
    always_comb begin
        wr_allow = prot_on ? '0 : prot_sel;
    end

    // Assemble the status word: flag at the bottom, address above it.
    always_comb begin
        stat_rdata = '0;
        stat_rdata[STAT_ERR_BIT]            = err_flag;
        stat_rdata[STAT_ADDR_LSB +: ADDR_W] = err_addr;
    end
endmodule

// File: rtl/wp_guard_chk.sv
// Module: wp_guard_chk
// Property checker for wp_guard, attached with bind. Observes ports and
// the internal protected-address hit.
module wp_guard_chk #(
    parameter int ADDR_W   = 8,
    parameter int PROT_CNT = 2,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hE4,
    parameter logic [23:0] KEY = 24'h444143
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                stat_rd,
    input logic [PROT_CNT-1:0] wr_allow,
    input logic                prot_on,
    input logic [31:0]         stat_rdata,
    input logic                prot_hit
);
    // R5
    locked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_on |-> (wr_allow == '0));

    // R4
    allow_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_allow));

    // R2
    key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == LOCK_ADDR && bus_wdata[31:8] == KEY)
        |=> (prot_on == $past(bus_wdata[0])));

    // R3
    badkey_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == LOCK_ADDR && bus_wdata[31:8] != KEY)
        |=> $stable(prot_on));

    // R6
    viol_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && prot_hit)
        |=> (stat_rdata[0] && stat_rdata[8 +: ADDR_W] == $past(bus_addr)));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(prot_on && prot_hit)) |=> (stat_rdata == '0));

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && !(prot_on && prot_hit)) |=> $stable(stat_rdata));
endmodule

bind wp_guard wp_guard_chk #(
    .ADDR_W   (ADDR_W),
    .PROT_CNT (PROT_CNT),
    .LOCK_ADDR(LOCK_ADDR),
    .KEY      (KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat_rd   (stat_rd),
    .wr_allow  (wr_allow),
    .prot_on   (prot_on),
    .stat_rdata(stat_rdata),
    .prot_hit  (prot_hit)
);

// File: tb/wp_guard_tb.sv
// Bench for wp_guard: behavioural reference model stepped every clock,
// outputs compared between edges.
module wp_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int PROT_CNT = 2;
    localparam logic [7:0] P0 = 8'h04;
    localparam logic [7:0] P1 = 8'h08;
    localparam logic [7:0] LOCK = 8'hE4;
    localparam logic [23:0] KEY = 24'h444143;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic stat_rd = 1'b0;
    logic [PROT_CNT-1:0] wr_allow;
    logic prot_on;
    logic [31:0] stat_rdata;

    int checks = 0;
    int errors = 0;

    // model state
    bit m_lock = 0;
    bit m_err = 0;
    int m_addr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .stat_rd(stat_rd), .wr_allow(wr_allow),
        .prot_on(prot_on), .stat_rdata(stat_rdata)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, compare against the model, then advance the model.
    task automatic step(input string tag, input bit wr, input logic [7:0] a,
                        input logic [31:0] d, input bit rd);
        int exp_allow;
        int exp_stat;
        bit is_prot;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; stat_rd = rd;
        #1;
        is_prot = wr && (a == P0 || a == P1);
        exp_allow = 0;
        if (wr && !m_lock && a == P0) exp_allow = 1;
        if (wr && !m_lock && a == P1) exp_allow = 2;
        exp_stat = (m_addr << 8) | int'(m_err);
        cmp(tag, "wr_allow", int'(wr_allow), exp_allow);
        cmp(tag, "prot_on", int'(prot_on), int'(m_lock));
        cmp(tag, "stat_rdata", int'(stat_rdata), exp_stat);
        @(posedge clk);
        if (rd) begin m_err = 0; m_addr = 0; end
        if (is_prot && m_lock) begin m_err = 1; m_addr = int'(a); end
        if (wr && a == LOCK && d[31:8] == KEY) m_lock = d[0];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step("R1", 0, 8'h00, 32'h0, 0);
        step("R1", 0, 8'h00, 32'h0, 1);
        // unlocked writes
        step("R4", 1, P0, 32'h1234, 0);
        step("R4", 1, P1, 32'h5678, 0);
        step("R10", 1, 8'h10, 32'hFFFF_FFFF, 0);
        step("R10", 0, 8'h00, 32'h0, 0);
        // wrong key cannot lock
        step("R3", 1, LOCK, 32'h4441_4201, 0);
        step("R3", 1, LOCK, 32'h0000_0001, 0);
        step("R3", 1, P0, 32'h0, 0);
        // keyed lock
        step("R2", 1, LOCK, {KEY, 8'h01}, 0);
        step("R5", 1, P0, 32'hAA, 0);
        step("R6", 0, 8'h00, 32'h0, 0);
        step("R8", 1, P1, 32'hBB, 0);
        step("R8", 1, 8'h10, 32'h0, 0);
        step("R10", 0, 8'h00, 32'h0, 0);
        // read and clear
        step("R7", 0, 8'h00, 32'h0, 1);
        step("R7", 0, 8'h00, 32'h0, 0);
        step("R7", 0, 8'h00, 32'h0, 1);
        // violation together with a read
        step("R9", 1, P0, 32'h1, 0);
        step("R9", 1, P1, 32'h2, 1);
        step("R9", 0, 8'h00, 32'h0, 0);
        // wrong key cannot unlock
        step("R3", 1, LOCK, {24'h444144, 8'h00}, 0);
        step("R3", 1, P1, 32'h3, 1);
        step("R3", 0, 8'h00, 32'h0, 1);
        // keyed unlock
        step("R2", 1, LOCK, {KEY, 8'h00}, 0);
        step("R4", 1, P1, 32'h4, 0);
        step("R4", 1, P0, 32'h5, 0);
        step("R1", 0, 8'h00, 32'h0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule